// File: doc/BRIEF.md
# Nibble Data Memory Indirect-Transfer Unit

This block is the data-memory execution unit of a small 4-bit controller. It owns a nibble-wide data memory. A cell address is made of a row field and a column field. The memory is cleared to zero on reset.

One row of that memory acts as the general-purpose register file. The row is chosen by an input, and a 4-bit register selector picks the cell within it. The unit runs one operation per start strobe:

- an add of a register and a memory operand, with a carry flag;
- a register-indirect store;
- a register-indirect load;
- a load of a 4-bit immediate into a register.

For an indirect access, the target keeps the row of the memory operand. Its column is the nibble currently held in the selected register. The load and the store use the same indirect cell, with source and destination swapped. No index register or row pointer ever changes an operand address.

Each operation spends one cycle reading and one cycle writing. A one-cycle done pulse follows the write. The nibble that was written is then shown on an output, so the memory contents can be observed through indirect loads.

Top module: `nibble_xfer_unit`

## Requirements
- R1: After reset every memory cell reads 0, `carry` is 0 and `done` is 0.
- R2: A memory operand `mem_opnd` splits into a row (bits 6:4) and a column (bits 3:0). Register `reg_sel` is the cell at row `reg_row`, column `reg_sel`. No other term modifies either address.
- R3: Opcode 2'b00 (add) writes the low 4 bits of register + memory operand into the register and sets `carry` to bit 4 of the 5-bit sum.
- R4: Opcode 2'b01 (indirect store) copies the cell at `mem_opnd` into the cell whose row is `mem_opnd[6:4]` and whose column is the register's contents. Example: operand 34H with the register holding 8 writes cell 38H.
- R5: Opcode 2'b10 (indirect load) copies the cell whose row is `mem_opnd[6:4]` and whose column is the register's contents into the cell at `mem_opnd`. Example: operand 34H with the register holding 0EH reads cell 3EH.
- R6: Opcodes 2'b01, 2'b10 and 2'b11 leave `carry` unchanged.
- R7: A start taken in idle raises `done` for exactly one cycle. This happens at the second rising edge after the edge that takes the start. `wr_nibble` then shows the nibble written by that operation.
- R8: A start that arrives while an operation is in progress is ignored. It writes no cell and produces no extra done pulse.
- R9: Opcode 2'b11 (immediate) writes `mem_opnd[3:0]` into the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opcode | input | 2 | 00 add, 01 indirect store, 10 indirect load, 11 immediate |
| reg_row | input | 3 | Row holding the register file |
| reg_sel | input | 4 | Register selector (column within the register row) |
| mem_opnd | input | 7 | Memory operand address; low nibble is the immediate for opcode 11 |
| done | output | 1 | One-cycle pulse after the write cycle |
| carry | output | 1 | Carry out of the last add |
| wr_nibble | output | 4 | Nibble written by the last completed operation |

## Verification
A corrupted cell stays hidden until an indirect load or an add reads it. At that point `wr_nibble` differs from the model's value at the done pulse of that operation. This can be many operations later, so the random mix keeps reading back rows it has just written.

A wrong column taken from the register, or a wrong row kept from the operand, does not show at once. It shows when the misplaced nibble is read back. A wrong state sequence shows much sooner: `done` arrives early, arrives late or pulses twice, within two cycles of the start.

A carry that is lost or changed by a move shows at the next done pulse.

// File: rtl/nxu_pkg.sv
package nxu_pkg;
   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_STIND = 2'b01,
      OP_LDIND = 2'b10,
      OP_IMM   = 2'b11
   } nxu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RD   = 2'b01,
      ST_WR   = 2'b10
   } nxu_state_e;
endpackage

// File: rtl/nxu_cell_array.sv
module nxu_cell_array #(
   parameter int ADDR_W         = 7,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("nxu_cell_array: ADDR_W out of range");
      end
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (we) begin
               cells[waddr] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we) cells[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/nxu_addr_gen.sv
module nxu_addr_gen #(
   parameter int ROW_W = 3,
   parameter int COL_W = 4
) (
   input  logic [ROW_W-1:0]       reg_row,
   input  logic [COL_W-1:0]       reg_sel,
   input  logic [ROW_W+COL_W-1:0] opnd,
   input  logic [COL_W-1:0]       reg_val,
   output logic [ROW_W+COL_W-1:0] reg_addr,
   output logic [ROW_W+COL_W-1:0] ind_addr
);
   localparam int AW = ROW_W + COL_W;

   logic [ROW_W-1:0] opnd_row;

   assign opnd_row = opnd[AW-1:COL_W];
   assign reg_addr = {reg_row, reg_sel};
   assign ind_addr = {opnd_row, reg_val};
endmodule

// File: rtl/nxu_adder.sv
module nxu_adder #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] full;

   assign full = {1'b0, a} + {1'b0, b};
   assign sum  = full[W-1:0];
   assign cout = full[W];
endmodule

// File: rtl/nibble_xfer_unit.sv
module nibble_xfer_unit
   import nxu_pkg::*;
#(
   parameter int ROW_W          = 3,
   parameter int COL_W          = 4,
   parameter int DATA_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [1:0]             opcode,
   input  logic [ROW_W-1:0]       reg_row,
   input  logic [COL_W-1:0]       reg_sel,
   input  logic [ROW_W+COL_W-1:0] mem_opnd,
   output logic                   done,
   output logic                   carry,
   output logic [DATA_W-1:0]      wr_nibble
);
   localparam int AW = ROW_W + COL_W;

   generate
      if (DATA_W != COL_W) begin : g_bad_width
         $error("nibble_xfer_unit: a cell must hold exactly one column index");
      end
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_dims
         $error("nibble_xfer_unit: row and column widths must be positive");
      end
   endgenerate

   nxu_state_e        state_q;
   nxu_op_e           op_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  sel_q;
   logic [AW-1:0]     opnd_q;

   logic [AW-1:0]     wr_addr_q;
   logic [DATA_W-1:0] wr_data_q;
   logic              wr_en_q;
   logic              cupd_q;
   logic              cnext_q;

   logic              done_q;
   logic              carry_q;
   logic [DATA_W-1:0] shown_q;

   logic [AW-1:0]     reg_addr;
   logic [AW-1:0]     ind_addr;
   logic [AW-1:0]     rd_b_addr;
   logic [DATA_W-1:0] reg_val;
   logic [DATA_W-1:0] opnd_val;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;

   logic [AW-1:0]     nx_addr;
   logic [DATA_W-1:0] nx_data;
   logic              nx_en;
   logic              nx_cupd;

   nxu_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
      .reg_row  (row_q),
      .reg_sel  (sel_q),
      .opnd     (opnd_q),
      .reg_val  (reg_val),
      .reg_addr (reg_addr),
      .ind_addr (ind_addr)
   );

   assign rd_b_addr = (op_q == OP_LDIND) ? ind_addr : opnd_q;

   nxu_cell_array #(
      .ADDR_W         (AW),
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (state_q == ST_WR && wr_en_q),
      .waddr   (wr_addr_q),
      .wdata   (wr_data_q),
      .raddr_a (reg_addr),
      .rdata_a (reg_val),
      .raddr_b (rd_b_addr),
      .rdata_b (opnd_val)
   );

   nxu_adder #(.W(DATA_W)) u_add (
      .a    (reg_val),
      .b    (opnd_val),
      .sum  (add_sum),
      .cout (add_cout)
   );

   always_comb begin
      nx_addr = reg_addr;
      nx_data = add_sum;
      nx_en   = 1'b1;
      nx_cupd = 1'b0;
      unique case (op_q)
         OP_ADD: begin
            nx_addr = reg_addr;
            nx_data = add_sum;
            nx_cupd = 1'b1;
         end
         OP_STIND: begin
            nx_addr = ind_addr;
            nx_data = opnd_val;
         end
         OP_LDIND: begin
            nx_addr = opnd_q;
            nx_data = opnd_val;
         end
         OP_IMM: begin
            nx_addr = reg_addr;
            nx_data = opnd_q[DATA_W-1:0];
         end
         default: nx_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= OP_ADD;
         row_q     <= '0;
         sel_q     <= '0;
         opnd_q    <= '0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         wr_en_q   <= 1'b0;
         cupd_q    <= 1'b0;
         cnext_q   <= 1'b0;
         done_q    <= 1'b0;
         carry_q   <= 1'b0;
         shown_q   <= '0;
      end else begin
         done_q <= (state_q == ST_WR);
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  op_q    <= nxu_op_e'(opcode);
                  row_q   <= reg_row;
                  sel_q   <= reg_sel;
                  opnd_q  <= mem_opnd;
                  state_q <= ST_RD;
               end
            end
            ST_RD: begin
               wr_addr_q <= nx_addr;
               wr_data_q <= nx_data;
               wr_en_q   <= nx_en;
               cupd_q    <= nx_cupd;
               cnext_q   <= add_cout;
               state_q   <= ST_WR;
            end
            ST_WR: begin
               if (cupd_q)  carry_q <= cnext_q;
               if (wr_en_q) shown_q <= wr_data_q;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign carry     = carry_q;
   assign wr_nibble = shown_q;
endmodule

// File: rtl/nxu_checker.sv
module nxu_checker
   import nxu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input nxu_state_e state,
   input nxu_op_e    op,
   input logic       done,
   input logic       carry
);
   assert_rd_then_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_RD |=> state == ST_WR);

   assert_wr_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_WR |=> (done && state == ST_IDLE));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> state != ST_RD);

   assert_move_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WR && op != OP_ADD) |=> $stable(carry));

   assert_idle_start_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start) |=> state == ST_RD);
endmodule

bind nibble_xfer_unit nxu_checker u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .state (state_q),
   .op    (op_q),
   .done  (done),
   .carry (carry)
);

// File: tb/nibble_xfer_unit_bench.sv
`timescale 1ns/1ps
module nibble_xfer_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] opcode = 2'b00;
   logic [2:0] reg_row = '0;
   logic [3:0] reg_sel = '0;
   logic [6:0] mem_opnd = '0;
   logic       done;
   logic       carry;
   logic [3:0] wr_nibble;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [3:0] ref_mem [128];
   logic       ref_carry;
   logic [3:0] ref_shown;

   always #2.5 clk = ~clk;

   nibble_xfer_unit u_nibble_xfer_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opcode    (opcode),
      .reg_row   (reg_row),
      .reg_sel   (reg_sel),
      .mem_opnd  (mem_opnd),
      .done      (done),
      .carry     (carry),
      .wr_nibble (wr_nibble)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] f_reg_addr(input logic [2:0] row, input logic [3:0] sel);
      return {row, sel};
   endfunction

   function automatic logic [6:0] f_ind_addr(input logic [6:0] m, input logic [3:0] col);
      return {m[6:4], col};
   endfunction

   // Reference model for opcodes of R3, R4, R5, R9; carry rule of R6.
   task automatic model(input logic [1:0] op, input logic [2:0] row,
                        input logic [3:0] sel, input logic [6:0] m);
      logic [6:0] ra;
      logic [6:0] ia;
      logic [4:0] s;
      ra = f_reg_addr(row, sel);
      ia = f_ind_addr(m, ref_mem[ra]);
      case (op)
         2'b00: begin
            s = {1'b0, ref_mem[ra]} + {1'b0, ref_mem[m]};
            ref_mem[ra] = s[3:0];
            ref_carry = s[4];
            ref_shown = s[3:0];
         end
         2'b01: begin
            ref_shown = ref_mem[m];
            ref_mem[ia] = ref_mem[m];
         end
         2'b10: begin
            ref_shown = ref_mem[ia];
            ref_mem[m] = ref_mem[ia];
         end
         default: begin
            ref_mem[ra] = m[3:0];
            ref_shown = m[3:0];
         end
      endcase
   endtask

   task automatic run_op(input string req, input logic [1:0] op, input logic [2:0] row,
                         input logic [3:0] sel, input logic [6:0] m);
      model(op, row, sel, m);
      @(negedge clk);
      opcode = op; reg_row = row; reg_sel = sel; mem_opnd = m; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R7", "done early", int'(done), 0);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R7", "done pulse", int'(done), 1);
      check(req, "written nibble", int'(wr_nibble), int'(ref_shown));
      check(req == "R3" ? "R3" : "R6", "carry", int'(carry), int'(ref_carry));
      @(negedge clk);
      check("R7", "done width", int'(done), 0);
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
         end
      end
   end

   initial begin
      int seed_dummy;
      for (int i = 0; i < 128; i++) ref_mem[i] = 4'h0;
      ref_carry = 1'b0;
      ref_shown = 4'h0;
      seed_dummy = $urandom(32'h5A17);

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "carry after reset", int'(carry), 0);
      check("R1", "done after reset", int'(done), 0);

      // R1: cells read back zero through indirect loads
      run_op("R1", 2'b10, 3'd0, 4'd0, 7'h25);
      run_op("R1", 2'b10, 3'd7, 4'd15, 7'h7A);

      // R9: immediates; R2: register row 0 maps register 5 to cell 05H
      run_op("R9", 2'b11, 3'd0, 4'd5, 7'h08);
      run_op("R9", 2'b11, 3'd3, 4'd4, 7'h0A);
      // R4: operand 34H, register 5 holds 8 -> cell 38H receives A
      run_op("R4", 2'b01, 3'd0, 4'd5, 7'h34);
      // R5: register 6 = 8, load from row 3 column 8 into 30H
      run_op("R9", 2'b11, 3'd0, 4'd6, 7'h08);
      run_op("R5", 2'b10, 3'd0, 4'd6, 7'h30);
      // R5: operand 34H, register B holds E -> source 3EH
      run_op("R9", 2'b11, 3'd0, 4'd11, 7'h0E);
      run_op("R9", 2'b11, 3'd3, 4'd14, 7'h06);
      run_op("R5", 2'b10, 3'd0, 4'd11, 7'h34);
      // R2: register row 3 register 4 is cell 34H, should now read 6
      run_op("R2", 2'b00, 3'd3, 4'd4, 7'h00);

      // R3: overflow add F + 3 -> 2 carry 1
      run_op("R9", 2'b11, 3'd0, 4'd3, 7'h0F);
      run_op("R9", 2'b11, 3'd1, 4'd1, 7'h03);
      run_op("R3", 2'b00, 3'd0, 4'd3, 7'h11);
      // R6: moves and immediate keep carry
      run_op("R6", 2'b01, 3'd0, 4'd3, 7'h11);
      run_op("R6", 2'b10, 3'd0, 4'd3, 7'h52);
      run_op("R6", 2'b11, 3'd2, 4'd2, 7'h01);
      // R3: register aliases operand (cell 03H twice), no carry
      run_op("R3", 2'b00, 3'd0, 4'd3, 7'h03);

      // R8: start held during the operation must not start another
      model(2'b11, 3'd4, 4'd9, 7'h07);
      @(negedge clk);
      opcode = 2'b11; reg_row = 3'd4; reg_sel = 4'd9; mem_opnd = 7'h07; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      opcode = 2'b11; reg_row = 3'd4; reg_sel = 4'd10; mem_opnd = 7'h0C;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R8", "done pulse", int'(done), 1);
      check("R8", "written nibble", int'(wr_nibble), 7);
      @(negedge clk);
      @(negedge clk);
      check("R8", "no second done", int'(done), 0);
      // cell 4AH must still be zero
      run_op("R8", 2'b11, 3'd0, 4'd0, 7'h0A);
      run_op("R8", 2'b10, 3'd0, 4'd0, 7'h40);

      // Random mix over few rows so writes get read back
      for (int n = 0; n < 600; n++) begin
         logic [1:0] op;
         logic [2:0] row;
         logic [3:0] sel;
         logic [6:0] m;
         op  = 2'($urandom_range(0, 3));
         row = 3'($urandom_range(0, 2));
         sel = 4'($urandom);
         m   = {3'($urandom_range(0, 2)), 4'($urandom)};
         case (op)
            2'b00:   run_op("R3", op, row, sel, m);
            2'b01:   run_op("R4", op, row, sel, m);
            2'b10:   run_op("R5", op, row, sel, m);
            default: run_op("R9", op, row, sel, m);
         endcase
      end

      report();
   end
endmodule